// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates 32-bit linear addresses to physical addresses. It reads a two-level radix table from memory. A translation request carries the linear address and two attributes: whether the access is a write and whether it comes from user mode. The walker first fetches one 32-bit directory entry, found through a 20-bit root frame number. Unless that entry maps a 4 MB page directly, it then fetches a 32-bit table entry. It checks the presence and permission bits at each level and returns either a physical address or a fault. A fault is reported with a cause code and the level that caused it.

After every check passes, the walker writes entries back to memory to record that the page was used. The accessed bit is set in each entry on the path. On a write, the modified bit is also set in the entry that maps the page. An entry is written back only when one of these bits actually changes. All memory traffic uses a single request port with one transaction in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: The directory entry is read from address {root_base, va[31:22], 2'b00}. For a 4 KB mapping, the table entry is then read from {dir_entry[31:12], va[21:12], 2'b00}.
- R2: A successful 4 KB translation returns rsp_paddr = {table_entry[31:12], va[11:0]} with rsp_level = 1.
- R3: A present directory entry with bit 7 set maps a 4 MB page. Exactly one read is made, and a successful result is rsp_paddr = {dir_entry[31:22], va[21:0]} with rsp_level = 0.
- R4: An entry with bit 0 (present) clear gives rsp_fault = 1 and rsp_code = 1. rsp_level is 0 for the directory and 1 for the table.
- R5: A write to an entry whose bit 1 (writable) is clear gives rsp_code = 2.
- R6: A user access to an entry whose bit 2 (user-allowed) is clear gives rsp_code = 3.
- R7: The directory entry is fully checked before the table entry is read. Within one entry the check order is present, then user, then writable. A successful response has rsp_code = 0 and rsp_fault = 0.
- R8: After a successful access, every entry read has bit 5 (accessed) set in memory. On a write, bit 6 (modified) is also set in the final entry. The modified bit of a directory entry that points to a table is left alone. The table entry is written back before the directory entry, and no other bits change.
- R9: No entry is written back when its value would not change, and a faulting access writes nothing.
- R10: A request is taken only while busy is low. busy rises in the cycle after acceptance and stays high up to and including the rsp_valid cycle, after which it falls. req_valid is ignored while busy is high.
- R11: Once mem_req is raised, it stays high with mem_addr, mem_we and mem_wdata unchanged until a cycle with mem_ack high. That cycle completes the transaction, and for a read mem_rdata is taken in it.
- R12: After reset, busy, mem_req and rsp_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 20 | Frame number of the directory |
| req_valid | input | 1 | Translation request |
| req_addr | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| busy | output | 1 | Walk in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation faulted |
| rsp_code | output | 2 | 0 ok, 1 not present, 2 write denied, 3 user denied |
| rsp_level | output | 1 | 0 directory, 1 table |
| rsp_paddr | output | 32 | Physical address on success, zero on fault |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Transaction is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value for writes |
| mem_ack | input | 1 | Transaction completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
Random walks pick the present, writable, user, accessed, modified and large-page bits independently at both levels, combined with random access kinds. This separates the fault priorities and the choice between the two mapping sizes. It also shows whether a writeback is issued or skipped against an independent model of the table. Directed cases cover three situations. First, a clean 4 KB walk, repeated once so the second pass needs no writes. Second, a write that must set only the modified bit. Third, a 4 MB write that sets both bits in one directory writeback. Further directed walks put each fault cause at a chosen level, including an entry that fails two checks at once. A request raised during a walk shows that acceptance is held off. The memory model stalls acknowledgements at random, so the request-hold rule is exercised on every transaction.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFS_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-OFS_W-1:0] root_base,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_addr,
  input  logic              req_write,
  input  logic              req_user,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [1:0]        rsp_code,
  output logic              rsp_level,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [VA_W-1:0]   mem_addr,
  output logic [VA_W-1:0]   mem_wdata,
  input  logic              mem_ack,
  input  logic [VA_W-1:0]   mem_rdata
);
  localparam int unsigned FR_W   = VA_W - OFS_W;
  localparam int unsigned BIG_LO = OFS_W + IDX_W;
  localparam int unsigned B_P = 0, B_W = 1, B_U = 2, B_A = 5, B_D = 6, B_BIG = 7;
  localparam logic [VA_W-1:0] A_M = VA_W'(1) << B_A;
  localparam logic [VA_W-1:0] D_M = VA_W'(1) << B_D;

  typedef enum logic [2:0] {
    S_IDLE, S_RDIR, S_CDIR, S_RTBL, S_CTBL, S_WTBL, S_WDIR, S_RESP
  } st_t;

  st_t st;
  logic [VA_W-1:0] va, de, te, pa;
  logic wr, usr, lvl;
  logic [1:0] code;

  function automatic logic [1:0] deny(input logic [VA_W-1:0] e, input logic w, input logic u);
    if (!e[B_P])           return 2'd1;
    else if (u && !e[B_U]) return 2'd3;
    else if (w && !e[B_W]) return 2'd2;
    else                   return 2'd0;
  endfunction

  wire             big      = de[B_BIG];
  wire [1:0]       dir_deny = deny(de, wr, usr);
  wire [1:0]       tbl_deny = deny(te, wr, usr);
  wire [VA_W-1:0]  de_new   = de | A_M | ((big && wr) ? D_M : '0);
  wire [VA_W-1:0]  te_new   = te | A_M | (wr ? D_M : '0);
  wire             de_chg   = de_new != de;
  wire             te_chg   = te_new != te;
  wire [VA_W-1:0]  dir_ptr  = {root_base, va[VA_W-1:BIG_LO], 2'b00};
  wire [VA_W-1:0]  tbl_ptr  = {de[VA_W-1:OFS_W], va[BIG_LO-1:OFS_W], 2'b00};
  wire             at_dir   = (st == S_RDIR) || (st == S_WDIR);

  assign busy      = st != S_IDLE;
  assign rsp_valid = st == S_RESP;
  assign rsp_fault = code != 2'd0;
  assign rsp_code  = code;
  assign rsp_level = lvl;
  assign rsp_paddr = pa;
  assign mem_req   = (st == S_RDIR) || (st == S_RTBL) || (st == S_WTBL) || (st == S_WDIR);
  assign mem_we    = (st == S_WTBL) || (st == S_WDIR);
  assign mem_addr  = at_dir ? dir_ptr : tbl_ptr;
  assign mem_wdata = (st == S_WDIR) ? de_new : te_new;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      va <= '0; de <= '0; te <= '0; pa <= '0;
      wr <= 1'b0; usr <= 1'b0; lvl <= 1'b0; code <= 2'd0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va  <= req_addr;
          wr  <= req_write;
          usr <= req_user;
          st  <= S_RDIR;
        end
        S_RDIR: if (mem_ack) begin
          de <= mem_rdata;
          st <= S_CDIR;
        end
        S_CDIR: begin
          lvl <= 1'b0;
          if (dir_deny != 2'd0) begin
            code <= dir_deny;
            pa   <= '0;
            st   <= S_RESP;
          end else if (big) begin
            code <= 2'd0;
            pa   <= {de[VA_W-1:BIG_LO], va[BIG_LO-1:0]};
            st   <= de_chg ? S_WDIR : S_RESP;
          end else begin
            st <= S_RTBL;
          end
        end
        S_RTBL: if (mem_ack) begin
          te <= mem_rdata;
          st <= S_CTBL;
        end
        S_CTBL: begin
          lvl <= 1'b1;
          if (tbl_deny != 2'd0) begin
            code <= tbl_deny;
            pa   <= '0;
            st   <= S_RESP;
          end else begin
            code <= 2'd0;
            pa   <= {te[VA_W-1:OFS_W], va[OFS_W-1:0]};
            st   <= te_chg ? S_WTBL : (de_chg ? S_WDIR : S_RESP);
          end
        end
        S_WTBL: if (mem_ack) st <= de_chg ? S_WDIR : S_RESP;
        S_WDIR: if (mem_ack) st <= S_RESP;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !busy);
  assert_hold_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  assert_wb_accessed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[B_A] && mem_wdata[B_P]);
  assert_small_ofs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault && rsp_level |-> rsp_paddr[OFS_W-1:0] == va[OFS_W-1:0]);
  assert_big_ofs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault && !rsp_level |-> rsp_paddr[BIG_LO-1:0] == va[BIG_LO-1:0]);
  assert_idle_mem_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  localparam logic [19:0] ROOT = 20'h00010;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_addr = '0;
  logic busy, rsp_valid, rsp_fault, rsp_level, mem_req, mem_we;
  logic [1:0] rsp_code;
  logic [31:0] rsp_paddr, mem_addr, mem_wdata;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] shadow [logic [31:0]];
  logic [31:0] rd_log [$];
  int n_wr = 0;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rst_n(rst_n), .root_base(ROOT),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write), .req_user(req_user),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_code(rsp_code),
    .rsp_level(rsp_level), .rsp_paddr(rsp_paddr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] rd_m(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction
  function automatic logic [31:0] rd_s(input logic [31:0] a);
    return shadow.exists(a) ? shadow[a] : 32'h0;
  endfunction

  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (rst_n && mem_req && $urandom_range(0, 2) != 0) begin
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        n_wr++;
      end else begin
        mem_rdata = rd_m(mem_addr);
        rd_log.push_back(mem_addr);
      end
      mem_ack = 1'b1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] v);
    mem[a] = v;
    shadow[a] = v;
  endtask

  function automatic logic [1:0] why(input logic [31:0] e, input bit w, input bit u);
    if (!e[0]) return 2'd1;
    if (u && !e[2]) return 2'd3;
    if (w && !e[1]) return 2'd2;
    return 2'd0;
  endfunction

  task automatic run(input string tag, input logic [31:0] a, input bit w, input bit u,
                     input bit poke = 1'b0);
    logic [31:0] pde_a, pte_a, d, t, nd, nt, pa;
    logic [1:0] code;
    bit lvl;
    int exp_rd, exp_wr, rd0, wr0, waitc;
    pde_a = {ROOT, a[31:22], 2'b00};
    d = rd_s(pde_a);
    pte_a = {d[31:12], a[21:12], 2'b00};
    exp_rd = 1; exp_wr = 0; lvl = 1'b0; pa = '0;
    code = why(d, w, u);
    if (code == 2'd0) begin
      if (d[7]) begin
        pa = {d[31:22], a[21:0]};
        nd = d | 32'h20 | (w ? 32'h40 : 32'h0);
        if (nd != d) begin shadow[pde_a] = nd; exp_wr++; end
      end else begin
        t = rd_s(pte_a);
        exp_rd = 2; lvl = 1'b1;
        code = why(t, w, u);
        if (code == 2'd0) begin
          pa = {t[31:12], a[11:0]};
          nt = t | 32'h20 | (w ? 32'h40 : 32'h0);
          if (nt != t) begin shadow[pte_a] = nt; exp_wr++; end
          nd = d | 32'h20;
          if (nd != d) begin shadow[pde_a] = nd; exp_wr++; end
        end
      end
    end
    rd0 = rd_log.size(); wr0 = n_wr;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_user = u;
    @(negedge clk);
    req_valid = poke;
    req_addr = ~a; req_write = ~w;
    chk({tag, " R10 busy after accept"}, 32'(busy), 32'd1);
    waitc = 0;
    while (!rsp_valid && waitc < 1000) begin
      @(negedge clk);
      waitc++;
    end
    req_valid = 1'b0;
    if (waitc >= 1000) begin
      fails++;
      $display("FAIL %s R10 no response act=%h exp=%h", tag, 32'(rsp_valid), 32'd1);
    end
    chk({tag, " R10 busy at response"}, 32'(busy), 32'd1);
    chk({tag, " R7 fault flag"}, 32'(rsp_fault), 32'(code != 2'd0));
    chk({tag, " code"}, 32'(rsp_code), 32'(code));
    chk({tag, " level"}, 32'(rsp_level), 32'(lvl));
    chk({tag, " paddr"}, rsp_paddr, pa);
    @(negedge clk);
    chk({tag, " R10 busy released"}, 32'(busy), 32'd0);
    repeat (3) @(negedge clk);
    chk({tag, " R10 no second walk"}, 32'(busy), 32'd0);
    chk({tag, " R1 read count"}, 32'(rd_log.size() - rd0), 32'(exp_rd));
    if (rd_log.size() > rd0) chk({tag, " R1 dir addr"}, rd_log[rd0], pde_a);
    if (exp_rd == 2 && rd_log.size() > rd0 + 1) chk({tag, " R1 tbl addr"}, rd_log[rd0+1], pte_a);
    chk({tag, " R9 write count"}, 32'(n_wr - wr0), 32'(exp_wr));
    chk({tag, " R8 dir entry"}, rd_m(pde_a), rd_s(pde_a));
    if (exp_rd == 2) chk({tag, " R8 tbl entry"}, rd_m(pte_a), rd_s(pte_a));
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R12 busy in reset", 32'(busy), 32'd0);
    chk("R12 mem_req in reset", 32'(mem_req), 32'd0);
    chk("R12 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 idle after reset", 32'(busy), 32'd0);

    put({ROOT, 10'd1, 2'b00}, {20'h00050, 12'h007});
    put({20'h00050, 10'd3, 2'b00}, {20'h12345, 12'h007});
    run("R2 clean 4K read", 32'h0040_3abc, 1'b0, 1'b1);
    chk("R2 literal paddr", rsp_paddr, 32'h1234_5abc);
    run("R9 repeat read no wb", 32'h0040_3123, 1'b0, 1'b1);
    run("R8 write sets modified", 32'h0040_3ff0, 1'b1, 1'b1);
    run("R9 repeat write no wb", 32'h0040_3004, 1'b1, 1'b0);

    put({ROOT, 10'd2, 2'b00}, {10'h2a5, 10'h0, 12'h083});
    run("R3 large write", 32'h008a_bcde, 1'b1, 1'b0);
    chk("R3 literal paddr", rsp_paddr, {10'h2a5, 22'h0a_bcde});

    put({ROOT, 10'd4, 2'b00}, 32'h0006_0006);
    run("R4 dir not present", 32'h0100_0000, 1'b0, 1'b0);
    put({ROOT, 10'd5, 2'b00}, {20'h00060, 12'h007});
    put({20'h00060, 10'd7, 2'b00}, 32'h9999_9006);
    run("R4 tbl not present", 32'h0140_7000, 1'b1, 1'b1);
    put({20'h00060, 10'd8, 2'b00}, 32'h7777_7005);
    run("R5 tbl write denied", 32'h0140_8010, 1'b1, 1'b1);
    put({ROOT, 10'd6, 2'b00}, {20'h00061, 12'h003});
    put({20'h00061, 10'd0, 2'b00}, 32'h5555_5007);
    run("R6 dir user denied", 32'h0180_0000, 1'b0, 1'b1);
    put({20'h00060, 10'd9, 2'b00}, 32'h4444_4001);
    run("R7 user before write", 32'h0140_9000, 1'b1, 1'b1);
    run("R7 super write denied", 32'h0140_9000, 1'b1, 1'b0);
    put({20'h00060, 10'd10, 2'b00}, 32'h3333_3027);
    run("R10 request while busy ignored", 32'h0140_a000, 1'b0, 1'b0, 1'b1);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, d, t;
      logic [9:0] di;
      di = 10'($urandom_range(16, 23));
      a = {di, 22'($urandom)};
      d = $urandom;
      d[0] = ($urandom_range(0, 7) != 0);
      d[7] = ($urandom_range(0, 3) == 0);
      if (!d[7]) d[31:12] = 20'h00080 + 20'(di);
      put({ROOT, di, 2'b00}, d);
      t = $urandom;
      t[0] = ($urandom_range(0, 7) != 0);
      put({20'h00080 + 20'(di), a[21:12], 2'b00}, t);
      run("R1 R5 R6 R8 random", a, 1'($urandom), 1'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule